// File: doc/BRIEF.md
# ECAM Configuration Access Decoder

This block sits on the root side of a PCI Express hierarchy. It accepts configuration reads and writes that arrive as AXI4-Lite accesses laid out in the enhanced configuration access mechanism (ECAM) format. It splits each address into bus, device, function and register fields. It then routes the access by comparing the bus field with the bus numbers held in the root port's own configuration space.

An access lands in one of four classes. Bus 0 is served locally by the root port. The secondary bus becomes a Type 0 request to the directly attached device. Buses above the secondary bus, up to the subordinate bus, become Type 1 requests. Everything else is refused with an error response. Type 0 and Type 1 requests are handed to the link side as a one-cycle request. The decoder then waits for a single completion before it answers on AXI4-Lite.

Only one access is in flight at a time. Local and refused accesses never leave the block.

Top module: `ecam_cfg_decoder`

## Requirements
- R1: Address bits [27:20] give the bus, [19:15] the device, [14:12] the function, and [11:2] the 10-bit dword register index (extended number in the upper four bits). Bits [1:0] and bits above 27 have no effect on decoding.
- R2: Bus 0 accesses are served locally with response OKAY (2'b00). Local dword 6 holds the bus numbers: primary in byte 0, secondary in byte 1, subordinate in byte 2, and byte 3 reads zero. A write updates only the bytes whose write strobe is set. Other local dwords read zero, and writes to them are ignored.
- R3: An access to the secondary bus with device 0 issues a request of kind 1 (Type 0). It carries the decoded fields. Its byte enables equal the write strobes for writes and 4'hF for reads.
- R4: An access to a bus greater than the secondary and not greater than the subordinate issues a request of kind 2 (Type 1).
- R5: An access to the secondary bus with a nonzero device issues no request and is answered SLVERR (2'b10).
- R6: Any other nonzero bus issues no request and is answered SLVERR. Reads of such a bus return 32'hFFFF_FFFF.
- R7: Once an access is accepted, all ready outputs stay low until its response handshake completes. A request is issued as a single-cycle pulse in the cycle after acceptance.
- R8: A completion with the error flag clear gives OKAY, and for reads it gives the completion data. A completion with the flag set gives SLVERR, and reads return all ones.
- R9: When a write (address and data valid together) and a read are offered in the same idle cycle, the write is accepted and the read waits.
- R10: A response is held valid, with unchanged code and data, until the manager accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address accepted |
| awaddr | input | ADDR_W | Write address in ECAM layout |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data accepted |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Write byte strobes |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response accepted |
| bresp | output | 2 | Write response code |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address accepted |
| araddr | input | ADDR_W | Read address in ECAM layout |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data accepted |
| rdata | output | DATA_W | Read data |
| rresp | output | 2 | Read response code |
| cfg_req_valid | output | 1 | One-cycle configuration request to the link |
| cfg_req_kind | output | 2 | 1 = Type 0, 2 = Type 1 |
| cfg_req_write | output | 1 | Request is a write |
| cfg_req_bus | output | 8 | Target bus |
| cfg_req_dev | output | 5 | Target device |
| cfg_req_func | output | 3 | Target function |
| cfg_req_reg | output | 10 | Target dword register index |
| cfg_req_be | output | DATA_W/8 | Byte enables |
| cfg_req_wdata | output | DATA_W | Write payload |
| cpl_valid | input | 1 | Completion for the outstanding request |
| cpl_err | input | 1 | Completion reports failure |
| cpl_data | input | DATA_W | Completion read data |

## Verification
A corrupted bus-number register shows up as soon as the next access is routed. A request of the wrong kind, or an unexpected SLVERR, appears one cycle after acceptance. A read of local dword 6 exposes the register directly. A control state that fails to return to idle shows as ready held low forever, which the bench sees on the next access. A stale request latch shows as a second request pulse, which is checked on every clock.

// File: rtl/ecam_pkg.sv
// Shared field widths, positions, request kinds and response codes
// for the configuration access decoder. Assumes the ECAM address layout.
package ecam_pkg;
    localparam int BUS_W    = 8;
    localparam int DEV_W    = 5;
    localparam int FUNC_W   = 3;
    localparam int REG_W    = 10;
    localparam int BUS_LSB  = 20;
    localparam int DEV_LSB  = 15;
    localparam int FUNC_LSB = 12;
    localparam int REG_LSB  = 2;
    localparam int NUM_BUSNUM = 3;                  // primary, secondary, subordinate
    localparam logic [REG_W-1:0] BUSNUM_DWORD = 10'd6;

    typedef enum logic [1:0] {
        KIND_LOCAL = 2'd0,
        KIND_TYPE0 = 2'd1,
        KIND_TYPE1 = 2'd2,
        KIND_UNSUP = 2'd3
    } cfg_kind_e;

    typedef struct packed {
        logic [BUS_W-1:0]  bus;
        logic [DEV_W-1:0]  dev;
        logic [FUNC_W-1:0] func;
        logic [REG_W-1:0]  reg_idx;
    } cfg_fields_t;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;
endpackage

// File: rtl/ecam_addr_split.sv
// Splits an ECAM-format address into bus, device, function and dword index.
// Assumes ADDR_W >= 28; byte-offset bits and bits above the bus field are ignored.
module ecam_addr_split
    import ecam_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output cfg_fields_t       fields
);
    localparam int TOP_LSB = BUS_LSB + BUS_W;

    // Field extraction (R1)
    assign fields.bus     = addr[BUS_LSB  +: BUS_W];
    assign fields.dev     = addr[DEV_LSB  +: DEV_W];
    assign fields.func    = addr[FUNC_LSB +: FUNC_W];
    assign fields.reg_idx = addr[REG_LSB  +: REG_W];

    // Bits deliberately left out of decoding
    logic unused_addr_bits;
    assign unused_addr_bits = ^{addr[ADDR_W-1:TOP_LSB], addr[REG_LSB-1:0]};
endmodule

// File: rtl/ecam_route.sv
// Classifies a decoded access against the secondary and subordinate buses.
// Assumes bus 0 always belongs to the root port and the link is point-to-point.
module ecam_route
    import ecam_pkg::*;
(
    input  cfg_fields_t      fields,
    input  logic [BUS_W-1:0] sec_bus,
    input  logic [BUS_W-1:0] sub_bus,
    output cfg_kind_e        kind
);
    // Priority: local, directly attached bus, downstream range, refuse
    always_comb begin
        if (fields.bus == '0)
            kind = KIND_LOCAL;
        else if (fields.bus == sec_bus)
            kind = (fields.dev == '0) ? KIND_TYPE0 : KIND_UNSUP;
        else if (fields.bus > sec_bus && fields.bus <= sub_bus)
            kind = KIND_TYPE1;
        else
            kind = KIND_UNSUP;
    end
endmodule

// File: rtl/ecam_bus_regs.sv
// Byte-wide bus-number registers with per-byte strobes.
// Assumes field i sits in byte lane i of the write data.
module ecam_bus_regs #(
    parameter int NUM_FIELDS = 3,
    parameter int FIELD_W    = 8,
    parameter int DATA_W     = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [DATA_W/8-1:0]           wstrb,
    input  logic [DATA_W-1:0]             wdata,
    output logic [NUM_FIELDS*FIELD_W-1:0] value
);
    localparam int STRB_W = DATA_W / 8;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        logic [FIELD_W-1:0] q;
        // Update one bus-number byte when its strobe is set
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && wstrb[i])
                q <= wdata[i*FIELD_W +: FIELD_W];
        end
        assign value[i*FIELD_W +: FIELD_W] = q;
    end

    // Lanes without a bus-number field
    logic unused_lanes;
    assign unused_lanes = ^{wstrb[STRB_W-1:NUM_FIELDS], wdata[DATA_W-1:NUM_FIELDS*FIELD_W]};
endmodule

// File: rtl/ecam_cfg_decoder.sv
// Root-side ECAM configuration access decoder. Accepts one AXI4-Lite access
// at a time, routes it as local, Type 0, Type 1 or refused, issues a
// one-cycle request to the link for Type 0/1 and answers after completion.
// Assumes DATA_W >= 32 and that the link returns exactly one completion.
module ecam_cfg_decoder
    import ecam_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                awvalid,
    output logic                awready,
    input  logic [ADDR_W-1:0]   awaddr,
    input  logic                wvalid,
    output logic                wready,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] wstrb,
    output logic                bvalid,
    input  logic                bready,
    output logic [1:0]          bresp,
    input  logic                arvalid,
    output logic                arready,
    input  logic [ADDR_W-1:0]   araddr,
    output logic                rvalid,
    input  logic                rready,
    output logic [DATA_W-1:0]   rdata,
    output logic [1:0]          rresp,
    output logic                cfg_req_valid,
    output logic [1:0]          cfg_req_kind,
    output logic                cfg_req_write,
    output logic [7:0]          cfg_req_bus,
    output logic [4:0]          cfg_req_dev,
    output logic [2:0]          cfg_req_func,
    output logic [9:0]          cfg_req_reg,
    output logic [DATA_W/8-1:0] cfg_req_be,
    output logic [DATA_W-1:0]   cfg_req_wdata,
    input  logic                cpl_valid,
    input  logic                cpl_err,
    input  logic [DATA_W-1:0]   cpl_data
);
    localparam int STRB_W  = DATA_W / 8;
    localparam int BNUM_W  = NUM_BUSNUM * BUS_W;

    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RESP} state_e;

    state_e              state_q;
    logic                take_wr, take_rd, accept;
    logic [ADDR_W-1:0]   addr_sel;
    cfg_fields_t         fld;
    cfg_kind_e           kind_now;
    logic [BNUM_W-1:0]   busnum;
    logic [BUS_W-1:0]    sec_bus, sub_bus;
    logic                bus_wr;
    logic [DATA_W-1:0]   local_rdata;

    logic                req_valid_q;
    logic                is_wr_q;
    cfg_kind_e           kind_q;
    cfg_fields_t         fld_q;
    logic [STRB_W-1:0]   be_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [1:0]          resp_q;
    logic [DATA_W-1:0]   rdata_q;

    // Write wins over read when both are offered while idle (R9)
    assign take_wr  = awvalid && wvalid;
    assign take_rd  = arvalid && !take_wr;
    assign accept   = (state_q == ST_IDLE) && (take_wr || take_rd);
    assign awready  = (state_q == ST_IDLE) && take_wr;
    assign wready   = (state_q == ST_IDLE) && take_wr;
    assign arready  = (state_q == ST_IDLE) && take_rd;
    assign addr_sel = take_wr ? awaddr : araddr;

    ecam_addr_split #(.ADDR_W(ADDR_W)) u_split (
        .addr   (addr_sel),
        .fields (fld)
    );

    assign sec_bus = busnum[BUS_W   +: BUS_W];
    assign sub_bus = busnum[2*BUS_W +: BUS_W];

    ecam_route u_route (
        .fields  (fld),
        .sec_bus (sec_bus),
        .sub_bus (sub_bus),
        .kind    (kind_now)
    );

    // Local write to the bus-number dword (R2)
    assign bus_wr = accept && take_wr && (kind_now == KIND_LOCAL)
                    && (fld.reg_idx == BUSNUM_DWORD);

    ecam_bus_regs #(
        .NUM_FIELDS (NUM_BUSNUM),
        .FIELD_W    (BUS_W),
        .DATA_W     (DATA_W)
    ) u_busregs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr),
        .wstrb (wstrb),
        .wdata (wdata),
        .value (busnum)
    );

    // Local read data: bus numbers at dword 6, zero elsewhere
    always_comb begin
        local_rdata = '0;
        if (fld.reg_idx == BUSNUM_DWORD)
            local_rdata[BNUM_W-1:0] = busnum;
    end

    // Access sequencing: accept, optionally wait for completion, respond
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            req_valid_q <= 1'b0;
            is_wr_q     <= 1'b0;
            kind_q      <= KIND_LOCAL;
            fld_q       <= '0;
            be_q        <= '0;
            wdata_q     <= '0;
            resp_q      <= RESP_OKAY;
            rdata_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        is_wr_q <= take_wr;
                        kind_q  <= kind_now;
                        fld_q   <= fld;
                        be_q    <= take_wr ? wstrb : '1;
                        wdata_q <= take_wr ? wdata : '0;
                        case (kind_now)
                            KIND_LOCAL: begin
                                state_q <= ST_RESP;
                                resp_q  <= RESP_OKAY;
                                rdata_q <= local_rdata;
                            end
                            KIND_UNSUP: begin
                                state_q <= ST_RESP;
                                resp_q  <= RESP_SLVERR;
                                rdata_q <= '1;
                            end
                            default: begin
                                state_q     <= ST_WAIT;
                                req_valid_q <= 1'b1;
                            end
                        endcase
                    end
                end
                ST_WAIT: begin
                    req_valid_q <= 1'b0;
                    if (cpl_valid) begin
                        state_q <= ST_RESP;
                        resp_q  <= cpl_err ? RESP_SLVERR : RESP_OKAY;
                        rdata_q <= cpl_err ? '1 : cpl_data;
                    end
                end
                ST_RESP: begin
                    if (is_wr_q ? bready : rready)
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign bvalid        = (state_q == ST_RESP) && is_wr_q;
    assign rvalid        = (state_q == ST_RESP) && !is_wr_q;
    assign bresp         = resp_q;
    assign rresp         = resp_q;
    assign rdata         = rdata_q;
    assign cfg_req_valid = req_valid_q;
    assign cfg_req_kind  = kind_q;
    assign cfg_req_write = is_wr_q;
    assign cfg_req_bus   = fld_q.bus;
    assign cfg_req_dev   = fld_q.dev;
    assign cfg_req_func  = fld_q.func;
    assign cfg_req_reg   = fld_q.reg_idx;
    assign cfg_req_be    = be_q;
    assign cfg_req_wdata = wdata_q;

    // R7
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid || rvalid || cfg_req_valid) |-> !(awready || arready));
    // R7
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid |=> !cfg_req_valid);
    // R3
    req_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid |-> (cfg_req_kind == 2'd1 || cfg_req_kind == 2'd2));
    // R5
    type0_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req_valid && cfg_req_kind == 2'd1) |-> (cfg_req_dev == '0 && cfg_req_bus == sec_bus));
    // R4
    type1_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req_valid && cfg_req_kind == 2'd2) |-> (cfg_req_bus > sec_bus && cfg_req_bus <= sub_bus));
    // R6
    err_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && rresp == RESP_SLVERR) |-> (rdata == {DATA_W{1'b1}}));
    // R9
    write_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid && wvalid) |-> !arready);
    // R10
    bhold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> (bvalid && $stable(bresp)));
    // R10
    rhold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rresp) && $stable(rdata)));
endmodule

// File: tb/tb_ecam_cfg_decoder.sv
// Bench: behavioural model of bus numbers and routing, checked cycle by cycle.
module tb_ecam_cfg_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        awvalid = 0, wvalid = 0, bready = 1, arvalid = 0, rready = 1;
    logic [31:0] awaddr = 0, wdata = 0, araddr = 0;
    logic [3:0]  wstrb = 0;
    logic        cpl_valid = 0, cpl_err = 0;
    logic [31:0] cpl_data = 0;
    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp, cfg_req_kind;
    logic [31:0] rdata, cfg_req_wdata;
    logic        cfg_req_valid, cfg_req_write;
    logic [7:0]  cfg_req_bus;
    logic [4:0]  cfg_req_dev;
    logic [2:0]  cfg_req_func;
    logic [9:0]  cfg_req_reg;
    logic [3:0]  cfg_req_be;

    int errors = 0;
    int checks = 0;
    int m_pri = 0, m_sec = 0, m_sub = 0;
    bit req_expected = 0;

    always #10 clk = ~clk;

    ecam_cfg_decoder dut (
        .clk(clk), .rst_n(rst_n),
        .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
        .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb),
        .bvalid(bvalid), .bready(bready), .bresp(bresp),
        .arvalid(arvalid), .arready(arready), .araddr(araddr),
        .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp),
        .cfg_req_valid(cfg_req_valid), .cfg_req_kind(cfg_req_kind),
        .cfg_req_write(cfg_req_write), .cfg_req_bus(cfg_req_bus),
        .cfg_req_dev(cfg_req_dev), .cfg_req_func(cfg_req_func),
        .cfg_req_reg(cfg_req_reg), .cfg_req_be(cfg_req_be),
        .cfg_req_wdata(cfg_req_wdata),
        .cpl_valid(cpl_valid), .cpl_err(cpl_err), .cpl_data(cpl_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Every clock: no request pulse unless the model expects one (R7)
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (cfg_req_valid && !req_expected) begin
                errors++;
                $display("FAIL R7 unexpected request: actual=1 expected=0");
            end
        end
    end

    // Model routing: 0 local, 1 Type 0, 2 Type 1, 3 refused
    function automatic int model_kind(input int b, input int d);
        if (b == 0) return 0;
        if (b == m_sec) return (d == 0) ? 1 : 3;
        if (b > m_sec && b <= m_sub) return 2;
        return 3;
    endfunction

    // One access; hold = cycles the manager delays accepting the response
    task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] d,
                          input logic [3:0] s, input bit cerr, input logic [31:0] cdata,
                          input int hold, input string tag);
        int k;
        logic [1:0]  eresp;
        logic [31:0] erd;
        k = model_kind(int'(a[27:20]), int'(a[19:15]));
        @(negedge clk);
        if (wr) begin awvalid = 1; wvalid = 1; awaddr = a; wdata = d; wstrb = s; end
        else begin arvalid = 1; araddr = a; end
        bready = (hold == 0);
        rready = (hold == 0);
        #1;
        chk({tag, " R7 ready while idle"}, wr ? 32'(awready && wready) : 32'(arready), 1);
        @(posedge clk);
        #1;
        awvalid = 0; wvalid = 0; arvalid = 0;
        if (k == 1 || k == 2) begin
            req_expected = 1;
            @(negedge clk);
            chk({tag, " R3/R4 request valid"}, 32'(cfg_req_valid), 1);
            chk({tag, " R3/R4 kind"}, 32'(cfg_req_kind), k);
            chk({tag, " R1 bus"}, 32'(cfg_req_bus), 32'(a[27:20]));
            chk({tag, " R1 dev"}, 32'(cfg_req_dev), 32'(a[19:15]));
            chk({tag, " R1 func"}, 32'(cfg_req_func), 32'(a[14:12]));
            chk({tag, " R1 reg"}, 32'(cfg_req_reg), 32'(a[11:2]));
            chk({tag, " R3 write flag"}, 32'(cfg_req_write), 32'(wr));
            chk({tag, " R3 byte enables"}, 32'(cfg_req_be), wr ? 32'(s) : 32'hF);
            if (wr) chk({tag, " R3 payload"}, cfg_req_wdata, d);
            chk({tag, " R7 busy ready low"}, 32'(awready || arready), 0);
            cpl_valid = 1; cpl_err = cerr; cpl_data = cdata;
            @(posedge clk);
            #1;
            cpl_valid = 0;
            req_expected = 0;
            eresp = cerr ? 2'b10 : 2'b00;
            erd = cerr ? 32'hFFFF_FFFF : cdata;
        end else if (k == 0) begin
            eresp = 2'b00;
            erd = (a[11:2] == 10'd6) ? {8'h00, 8'(m_sub), 8'(m_sec), 8'(m_pri)} : 32'h0;
            if (wr && a[11:2] == 10'd6) begin
                if (s[0]) m_pri = int'(d[7:0]);
                if (s[1]) m_sec = int'(d[15:8]);
                if (s[2]) m_sub = int'(d[23:16]);
            end
        end else begin
            eresp = 2'b10;
            erd = 32'hFFFF_FFFF;
        end
        @(negedge clk);
        chk({tag, " R7 request is one pulse"}, 32'(cfg_req_valid), 0);
        if (wr) begin
            chk({tag, " R8 bvalid"}, 32'(bvalid), 1);
            chk({tag, " R8 bresp"}, 32'(bresp), 32'(eresp));
        end else begin
            chk({tag, " R8 rvalid"}, 32'(rvalid), 1);
            chk({tag, " R8 rresp"}, 32'(rresp), 32'(eresp));
            chk({tag, " R8 rdata"}, rdata, erd);
        end
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk({tag, " R10 response held"}, wr ? 32'(bvalid) : 32'(rvalid), 1);
            chk({tag, " R10 code stable"}, wr ? 32'(bresp) : 32'(rresp), 32'(eresp));
            if (!wr) chk({tag, " R10 data stable"}, rdata, erd);
        end
        bready = 1; rready = 1;
        @(negedge clk);
        chk({tag, " R10 response retired"}, 32'(bvalid || rvalid), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("reset bvalid", 32'(bvalid), 0);
        chk("reset rvalid", 32'(rvalid), 0);
        chk("reset request", 32'(cfg_req_valid), 0);
        rst_n = 1;
        // R2 bus numbers reset to zero
        access(0, 32'h0000_0018, 0, 0, 0, 0, 0, "R2 read busnum at reset");
        // R6 nothing programmed: bus 7 refused
        access(0, 32'h0070_0000, 0, 0, 0, 0, 0, "R6 unprogrammed bus");
        // R2 program pri=0 sec=7 sub=0x0A; byte 3 discarded
        access(1, 32'h0000_0018, 32'hAA0A_0700, 4'b0111, 0, 0, 0, "R2 program busnum");
        access(0, 32'h0000_0018, 0, 0, 0, 0, 0, "R2 readback");
        // R2 strobe only byte 0
        access(1, 32'h0000_0018, 32'hFFFF_FF05, 4'b0001, 0, 0, 0, "R2 strobe");
        access(0, 32'h0000_0018, 0, 0, 0, 0, 0, "R2 strobe readback");
        // R2 other local dword ignores writes and reads zero
        access(1, 32'h0000_0040, 32'h1234_5678, 4'hF, 0, 0, 0, "R2 other dword write");
        access(0, 32'h0000_0040, 0, 0, 0, 0, 0, "R2 other dword read");
        // R3 Type 0 write to BAR0 offset of attached device
        access(1, 32'h0070_0010, 32'h1234_5678, 4'hF, 0, 0, 0, "R3 type0 write");
        access(0, 32'h0070_0000, 0, 0, 0, 32'h5A5A_1234, 0, "R3 type0 read");
        // R5 nonzero device on secondary bus
        access(0, 32'h0070_8000, 0, 0, 0, 0, 0, "R5 dev1 read");
        access(1, 32'h0071_0004, 32'h1, 4'h1, 0, 0, 0, "R5 dev2 write");
        // R4 + R1 Type 1 with ignored bits, error completion (R8)
        access(1, 32'hF081_DA3F, 32'hCAFE_F00D, 4'b1010, 1, 0, 0, "R4 type1 write err cpl");
        access(0, 32'h00A2_3004, 0, 0, 0, 32'h0BAD_CAFE, 0, "R4 type1 top bus");
        access(0, 32'h00A2_3004, 0, 0, 1, 32'h0, 0, "R8 type1 read err cpl");
        // R6 above subordinate and below secondary
        access(0, 32'h00B0_0000, 0, 0, 0, 0, 0, "R6 above sub");
        access(1, 32'h0060_0000, 32'h0, 4'hF, 0, 0, 0, "R6 below sec");
        // R10 held responses
        access(0, 32'h0000_0018, 0, 0, 0, 0, 3, "R10 local hold");
        access(1, 32'h0090_0008, 32'h7, 4'hF, 0, 0, 2, "R10 type1 hold");
        // R9 write and read offered together
        @(negedge clk);
        awvalid = 1; wvalid = 1; awaddr = 32'h0000_0040; wdata = 0; wstrb = 4'hF;
        arvalid = 1; araddr = 32'h0000_0018;
        #1;
        chk("R9 write accepted", 32'(awready && wready), 1);
        chk("R9 read held off", 32'(arready), 0);
        @(posedge clk);
        #1;
        awvalid = 0; wvalid = 0;
        @(negedge clk);
        chk("R9 write response first", 32'(bvalid), 1);
        chk("R7 read blocked while busy", 32'(arready), 0);
        @(negedge clk);
        chk("R9 read accepted after", 32'(arready), 1);
        @(posedge clk);
        #1;
        arvalid = 0;
        @(negedge clk);
        chk("R9 read response", 32'(rvalid), 1);
        chk("R9 read data", rdata, {8'h00, 8'(m_sub), 8'(m_sec), 8'(m_pri)});
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule